// File: doc/BRIEF.md
# Pattern Memory Fill Engine

This block writes one repeated pixel pattern over a range of word addresses in memory. Software first programs a first address, a stop address and a pattern value through a small register port. It then writes a control word with the run bit set. The engine issues one 32-bit word write per accepted handshake on a valid/ready write port. The data are packed from the low 16, low 24 or all 32 bits of the pattern value.

When the last word is accepted, the run bit drops. A pending flag is then raised on the `irq` output, unless the control word masked it. Software clears the flag by writing 1 to the flag register. A free-running counter totals every accepted write, so that traffic can be watched over time.

Register offsets (byte offsets on `reg_addr`): 0x00 first address, 0x04 stop address, 0x08 pattern value, 0x0C control, 0x10 pending flag, 0x14 write counter (read-only).

Top module: `pattern_fill_engine`

## Requirements
- R1: After reset every register reads 0, `mem_valid` is 0 and `irq` is 0. A read of offset A presents its value on `reg_rdata` one clock after `reg_addr` = A is sampled.
- R2: Writing control (0x0C) with bit 0 = 1 while idle starts a fill. `mem_valid` is high in the following cycle at the first address. Control bit 0 reads 1 while the fill runs and 0 once the last word is accepted.
- R3: Write addresses run upward in steps of 4. They start at the first address and stop before the stop address (exclusive). Address bits 1:0 of both registers are ignored.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold. The address advances only on a cycle with both high.
- R5: With control bits 9:8 = 0 (16-bit), each word is the low 16 bits of the value placed in both halves.
- R6: With bits 9:8 = 1 (24-bit), the value's bytes v[7:0], v[15:8], v[23:16] repeat as a byte stream, little-endian within each word. Word k byte i is stream byte (4k+i) mod 3, so the data repeat every three words.
- R7: With bits 9:8 = 2 (32-bit), every word is the whole value. The reserved code 3 behaves as 32-bit.
- R8: On acceptance of the last word, the pending flag (0x10 bit 0, also the `irq` output) is set in the same edge, unless control bit 1 (mask) is 1.
- R9: Writing 1 to 0x10 bit 0 clears the flag. Writing 0 leaves it unchanged.
- R10: While a fill runs, writes to offsets 0x00–0x0C are ignored, including a second run bit.
- R11: A run bit written when the stop word is not above the first word starts nothing: no write, no flag, and control bit 0 stays 0.
- R12: The 32-bit counter at 0x14 increases by one per accepted write and is never reset by a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 32 | Word to write |
| irq | output | 1 | Completion flag pending |

## Verification
The first word is due on the memory port one clock after the edge that samples the control write. Each later word appears one clock after the acceptance of the previous one. The bench's monitor samples the handshake half a period before each edge, so that exactly the accepted words are popped from the scoreboard queue and compared. The flag and the counter change on the edge that accepts the last word. A register read returns its value one edge after the offset is presented, so every readback is taken just after that edge.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_24  = 2'd1,
    SZ_32  = 2'd2,
    SZ_RSV = 2'd3
  } fill_size_e;

  localparam logic [4:0] OFF_FIRST = 5'h00;
  localparam logic [4:0] OFF_STOP  = 5'h04;
  localparam logic [4:0] OFF_VALUE = 5'h08;
  localparam logic [4:0] OFF_CTRL  = 5'h0C;
  localparam logic [4:0] OFF_FLAG  = 5'h10;
  localparam logic [4:0] OFF_COUNT = 5'h14;
endpackage

// File: rtl/pfe_pack.sv
module pfe_pack
  import pfe_pkg::*;
(
  input  logic [31:0] value,
  input  fill_size_e  size,
  input  logic [1:0]  phase,
  output logic [31:0] word
);
  logic [7:0] b0, b1, b2;
  assign b0 = value[7:0];
  assign b1 = value[15:8];
  assign b2 = value[23:16];

  always_comb begin
    case (size)
      SZ_16: word = {value[15:0], value[15:0]};
      SZ_24: begin
        case (phase)
          2'd0:    word = {b0, b2, b1, b0};
          2'd1:    word = {b1, b0, b2, b1};
          default: word = {b2, b1, b0, b2};
        endcase
      end
      default: word = value;
    endcase
  end
endmodule

// File: rtl/pfe_wcount.sv
module pfe_wcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  a_r12_count_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> count == $past(count) + 1'b1);
  a_r12_count_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/pfe_seq.sv
module pfe_seq
  import pfe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  fill_size_e        go_size,
  input  logic [ADDR_W-1:0] cfg_first,
  input  logic [ADDR_W-1:0] cfg_stop,
  input  logic [31:0]       cfg_value,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              busy,
  output logic              done,
  output logic              accept
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] waddr;
  logic [1:0]      phase, nxt_phase, sel_phase;
  fill_size_e      run_size, sel_size;
  logic [31:0]     packed_word;
  logic            last;

  assign nxt_phase = (phase == 2'd2) ? 2'd0 : phase + 2'd1;
  assign sel_phase = go ? 2'd0 : nxt_phase;
  assign sel_size  = go ? go_size : run_size;
  assign last      = (waddr + 1'b1) == cfg_stop[ADDR_W-1:2];
  assign accept    = busy && mem_ready;
  assign done      = accept && last;
  assign mem_valid = busy;
  assign mem_addr  = {waddr, 2'b00};

  pfe_pack u_pack (
    .value (cfg_value),
    .size  (sel_size),
    .phase (sel_phase),
    .word  (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      waddr    <= '0;
      phase    <= 2'd0;
      run_size <= SZ_16;
      mem_data <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      waddr    <= cfg_first[ADDR_W-1:2];
      phase    <= 2'd0;
      run_size <= go_size;
      mem_data <= packed_word;
    end else if (accept) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        waddr    <= waddr + 1'b1;
        phase    <= nxt_phase;
        mem_data <= packed_word;
      end
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + 4));
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[ADDR_W-1:2] < cfg_stop[ADDR_W-1:2]) &&
                  (mem_addr[ADDR_W-1:2] >= cfg_first[ADDR_W-1:2]));
  a_r6_phase_legal: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> phase != 2'd3);
endmodule

// File: rtl/pfe_regs.sv
module pfe_regs
  import pfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [CNT_W-1:0]  wcount,
  output logic [ADDR_W-1:0] cfg_first,
  output logic [ADDR_W-1:0] cfg_stop,
  output logic [31:0]       cfg_value,
  output logic              go,
  output fill_size_e        go_size,
  output logic              irq
);
  logic       mask;
  fill_size_e size;
  logic       cfg_wr, flag_clr, flag_set;

  assign cfg_wr   = reg_we && !busy;
  assign go_size  = fill_size_e'(reg_wdata[9:8]);
  assign go       = cfg_wr && (reg_addr == OFF_CTRL) && reg_wdata[0] &&
                    (cfg_first[ADDR_W-1:2] < cfg_stop[ADDR_W-1:2]);
  assign flag_set = done && !mask;
  assign flag_clr = reg_we && (reg_addr == OFF_FLAG) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_first <= '0;
      cfg_stop  <= '0;
      cfg_value <= '0;
      mask      <= 1'b0;
      size      <= SZ_16;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cfg_wr) begin
        case (reg_addr)
          OFF_FIRST: cfg_first <= reg_wdata[ADDR_W-1:0];
          OFF_STOP:  cfg_stop  <= reg_wdata[ADDR_W-1:0];
          OFF_VALUE: cfg_value <= reg_wdata;
          OFF_CTRL: begin
            mask <= reg_wdata[1];
            size <= go_size;
          end
          default: ;
        endcase
      end
      if (flag_set) irq <= 1'b1;
      else if (flag_clr) irq <= 1'b0;
      case (reg_addr)
        OFF_FIRST: reg_rdata <= 32'(cfg_first);
        OFF_STOP:  reg_rdata <= 32'(cfg_stop);
        OFF_VALUE: reg_rdata <= cfg_value;
        OFF_CTRL:  reg_rdata <= {22'd0, size, 6'd0, mask, busy};
        OFF_FLAG:  reg_rdata <= {31'd0, irq};
        OFF_COUNT: reg_rdata <= 32'(wcount);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    done && !mask |=> irq);
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    !irq && !(done && !mask) |=> !irq);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !done |=> !irq);
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_first) && $stable(cfg_stop) && $stable(cfg_value));
endmodule

// File: rtl/pattern_fill_engine.sv
module pattern_fill_engine
  import pfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              irq
);
  logic [ADDR_W-1:0] cfg_first, cfg_stop;
  logic [31:0]       cfg_value;
  logic              go, busy, done, accept;
  fill_size_e        go_size;
  logic [CNT_W-1:0]  wcount;

  pfe_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done      (done),
    .wcount    (wcount),
    .cfg_first (cfg_first),
    .cfg_stop  (cfg_stop),
    .cfg_value (cfg_value),
    .go        (go),
    .go_size   (go_size),
    .irq       (irq)
  );

  pfe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_size   (go_size),
    .cfg_first (cfg_first),
    .cfg_stop  (cfg_stop),
    .cfg_value (cfg_value),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .busy      (busy),
    .done      (done),
    .accept    (accept)
  );

  pfe_wcount #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (accept),
    .count (wcount)
  );
endmodule

// File: tb/tb_pattern_fill_engine.sv
module tb_pattern_fill_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  int accepted = 0;
  logic [63:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_mode = 1'b0;
  string       cur_req = "R3";

  always #10 clk = ~clk;

  pattern_fill_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: drives ready at the falling edge, then records what the next edge accepts.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_mode ? (lfsr[0] & ~lfsr[3]) : 1'b1;
    #1;
    if (!rst && mem_valid && mem_ready) begin
      accepted++;
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL %s actual=%h expected=none (unexpected write)", cur_req, mem_addr);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        check("R3", mem_addr, e[63:32]);
        check(cur_req, mem_data, e[31:0]);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #2;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] v, input int sz, input int k);
    logic [31:0] w;
    logic [7:0] st [3];
    st[0] = v[7:0]; st[1] = v[15:8]; st[2] = v[23:16];
    if (sz == 0) w = {v[15:0], v[15:0]};
    else if (sz == 1) begin
      for (int i = 0; i < 4; i++) w[8*i +: 8] = st[(4*k + i) % 3];
    end else w = v;
    return w;
  endfunction

  task automatic run_fill(input logic [31:0] s, input logic [31:0] e, input logic [31:0] v,
                          input int sz, input logic msk);
    int n = 0;
    for (logic [31:0] a = {s[31:2], 2'b00}; a < {e[31:2], 2'b00}; a += 4) begin
      expq.push_back({a, expect_word(v, sz, n)});
      n++;
    end
    wr(5'h00, s);
    wr(5'h04, e);
    wr(5'h08, v);
    wr(5'h0C, {22'd0, 2'(sz), 6'd0, msk, 1'b1});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #3;
      if (!mem_valid) break;
    end
    check("R2", {31'd0, mem_valid}, 32'd0);
    check("R3", expq.size(), 0);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1: reset state
    check("R1", {31'd0, mem_valid}, 0);
    check("R1", {31'd0, irq}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(5'(4 * a), r);
      check("R1", r, 0);
    end

    // R5: 16-bit, ready always high
    cur_req = "R5";
    run_fill(32'h1000, 32'h1010, 32'hDEAD_BEEF, 0, 1'b0);
    wait_idle();
    check("R8", {31'd0, irq}, 1);
    rd(5'h10, r); check("R8", r, 1);
    rd(5'h0C, r); check("R2", r[0], 0);
    wr(5'h10, 32'h0); check("R9", {31'd0, irq}, 1);
    wr(5'h10, 32'h1); check("R9", {31'd0, irq}, 0);

    // R6: 24-bit rotation with stalls
    stall_mode = 1'b1;
    cur_req = "R6";
    run_fill(32'h2000, 32'h201C, 32'h00A1_B2C3, 1, 1'b0);
    rd(5'h0C, r); check("R2", r[0], 1);
    wait_idle();
    check("R8", {31'd0, irq}, 1);
    wr(5'h10, 32'h1);

    // R7: 32-bit, masked; low address bits ignored (R3)
    cur_req = "R7";
    run_fill(32'h3003, 32'h300B, 32'h1234_5678, 2, 1'b1);
    wait_idle();
    check("R8", {31'd0, irq}, 0);
    run_fill(32'h3100, 32'h3108, 32'hCAFE_F00D, 3, 1'b1);
    wait_idle();
    check("R8", {31'd0, irq}, 0);

    // R10: writes during a run are ignored
    cur_req = "R10";
    run_fill(32'h4000, 32'h40A0, 32'h0055_AA33, 1, 1'b0);
    wr(5'h00, 32'h9000);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0000_0201);
    rd(5'h0C, r); check("R10", r, 32'h0000_0101);
    wait_idle();
    rd(5'h00, r); check("R10", r, 32'h4000);
    rd(5'h08, r); check("R10", r, 32'h0055_AA33);
    wr(5'h10, 32'h1);

    // R11: empty range
    wr(5'h00, 32'h5000);
    wr(5'h04, 32'h5003);
    wr(5'h0C, 32'h1);
    repeat (3) @(negedge clk);
    #3 check("R11", {31'd0, mem_valid}, 0);
    rd(5'h0C, r); check("R11", r[0], 0);
    check("R11", {31'd0, irq}, 0);

    // R12: counter totals accepted writes
    rd(5'h14, r); check("R12", r, accepted);
    rd(5'h14, r); check("R12", r, accepted);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule